// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor and Clock Reference Selector

This block watches the recovered dual-rail receive data of a primary-rate line interface. It counts the bit periods that carry no mark. When 32 such periods come in a row it raises a loss-of-signal flag. While the flag is up, it holds both outgoing receive rails at their inactive level. A mark is any rail sampled low in a bit period, and the flag drops on the first mark that arrives.

The same block decides which reference the downstream clock loop must follow. The choices are the recovered line clock, an external sync clock, or a free-running centered frequency. The choice depends on the master/slave strap, the loss-of-signal state, and whether the sync input is toggling. Sync activity is judged by a window of local clock cycles, and the length of that window depends on the selected line standard (T1 or CEPT).

Everything runs on one local clock. Bit periods are marked by a one-cycle enable taken from the recovered clock, and the sync input is treated as asynchronous.

Top module: `los_ref_select`

## Requirements
- R1: A mark is a bit period (bitEn high) in which rxPosN or rxNegN is 0. losFlag goes to 1 at the end of the 32nd consecutive bit period without a mark, and never after only 31.
- R2: While losFlag is 1 at a bit period, the rail outputs produced for that bit are both 1 (inactive), whatever the inputs carry.
- R3: While losFlag is 0, outPosN/outNegN take the values of rxPosN/rxNegN on the clock edge where bitEn is high, and they hold their values on every cycle where bitEn is low.
- R4: The first mark seen while losFlag is 1 clears losFlag on that same edge. That bit is still output as idle (both 1), and the next bit passes through unchanged.
- R5: refSel encodes 2'b00 for the recovered line clock, 2'b01 for the sync clock and 2'b10 for the centered free-running reference. In slave mode (masterMode=0) with losFlag=0 it is 2'b00.
- R6: In slave mode with losFlag=1, refSel is 2'b01 when the sync clock is present and 2'b10 when it is absent.
- R7: In master mode (masterMode=1), refSel is 2'b01 when the sync clock is present and 2'b10 otherwise, independent of losFlag.
- R8: A rising edge on syncClk passes through a two-flop synchronizer and marks the sync clock present from the third clock edge onward. Presence lasts exactly WIN clock edges after that without a new edge, then drops. WIN is 16 when t1Mode=0 and 24 when t1Mode=1.
- R9: After reset, losFlag is 0, both rail outputs are 1, and the sync clock counts as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per recovered bit period |
| rxPosN | input | 1 | Recovered positive-mark rail, active low |
| rxNegN | input | 1 | Recovered negative-mark rail, active low |
| syncClk | input | 1 | External sync clock, asynchronous |
| masterMode | input | 1 | 1 selects master, 0 slave |
| t1Mode | input | 1 | 1 selects T1 window length, 0 CEPT |
| losFlag | output | 1 | Loss-of-signal indication |
| outPosN | output | 1 | Gated positive-mark rail, active low |
| outNegN | output | 1 | Gated negative-mark rail, active low |
| refSel | output | 2 | Clock-loop reference choice |

## Verification
On every cycle, the assertions check several invariants:
- the rails go idle after a bit taken under loss of signal;
- the rails hold between bit strobes;
- a mark clears the flag;
- the flag rises only on an empty bit;
- master mode never picks the line clock;
- the select code stays a legal one-hot value;
- sync presence follows a detected edge.

The exact 31-versus-32 boundary, the idle output on the clearing bit, and the exact length of both sync windows can only be shown by the bench's scenarios. So can the full decode over master mode, loss of signal and sync presence, which the bench sweeps exhaustively against arithmetic expectations.

// File: rtl/los_ref_pkg.sv
package los_ref_pkg;

  typedef enum logic [1:0] {
    REF_LINE   = 2'b00,
    REF_SYNC   = 2'b01,
    REF_CENTER = 2'b10
  } refSel_e;

  typedef struct packed {
    logic capture;    // take a new bit into the rail registers
    logic forceIdle;  // drive both rails inactive for this bit
  } railCtl_t;

endpackage

// File: rtl/los_ref_datapath.sv
module los_ref_datapath
  import los_ref_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxPosN,
  input  logic     rxNegN,
  input  logic     syncClk,
  input  railCtl_t ctl,
  output logic     markSeen,
  output logic     syncEdge,
  output logic     outPosN,
  output logic     outNegN
);

  logic [SYNC_STAGES:0] syncPipe;

  assign markSeen = !rxPosN || !rxNegN;

  generate
    for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncPipe[0] <= 1'b0;
          else       syncPipe[0] <= syncClk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncPipe[i] <= 1'b0;
          else       syncPipe[i] <= syncPipe[i-1];
        end
      end
    end
  endgenerate

  assign syncEdge = syncPipe[SYNC_STAGES-1] && !syncPipe[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPosN <= 1'b1;
      outNegN <= 1'b1;
    end else if (ctl.capture) begin
      outPosN <= ctl.forceIdle ? 1'b1 : rxPosN;
      outNegN <= ctl.forceIdle ? 1'b1 : rxNegN;
    end
  end

  assert_idle_rails_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.forceIdle) |=> (outPosN && outNegN));

  assert_hold_between_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(outPosN) && $stable(outNegN)));

endmodule

// File: rtl/los_ref_ctrl.sv
module los_ref_ctrl
  import los_ref_pkg::*;
#(
  parameter int LOS_BITS = 32,
  parameter int WIN_CEPT = 16,
  parameter int WIN_T1   = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       markSeen,
  input  logic       syncEdge,
  input  logic       masterMode,
  input  logic       t1Mode,
  output railCtl_t   ctl,
  output logic       losFlag,
  output logic       syncPresent,
  output logic [1:0] refSel
);

  localparam int ZW     = $clog2(LOS_BITS + 1);
  localparam int WIN_MX = (WIN_T1 > WIN_CEPT) ? WIN_T1 : WIN_CEPT;
  localparam int WW     = $clog2(WIN_MX + 1);
  localparam logic [ZW-1:0] ZERO_LAST = ZW'(LOS_BITS - 1);
  localparam logic [ZW-1:0] ZERO_SAT  = ZW'(LOS_BITS);

  logic [ZW-1:0] zeroCnt;
  logic [WW-1:0] winCnt;
  logic [WW-1:0] winLast;
  refSel_e       refNext;

  assign ctl.capture   = bitEn;
  assign ctl.forceIdle = losFlag;

  // zero-run counter and loss-of-signal state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroCnt <= '0;
      losFlag <= 1'b0;
    end else if (bitEn) begin
      if (markSeen) begin
        zeroCnt <= '0;
        losFlag <= 1'b0;
      end else begin
        if (zeroCnt != ZERO_SAT) zeroCnt <= zeroCnt + 1'b1;
        if (zeroCnt >= ZERO_LAST) losFlag <= 1'b1;
      end
    end
  end

  // sync activity window
  assign winLast = t1Mode ? WW'(WIN_T1 - 1) : WW'(WIN_CEPT - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt      <= '0;
      syncPresent <= 1'b0;
    end else if (syncEdge) begin
      winCnt      <= '0;
      syncPresent <= 1'b1;
    end else if (syncPresent) begin
      if (winCnt >= winLast) syncPresent <= 1'b0;
      else                   winCnt <= winCnt + 1'b1;
    end
  end

  // reference decode
  always_comb begin
    if (!masterMode && !losFlag) refNext = REF_LINE;
    else if (syncPresent)        refNext = REF_SYNC;
    else                         refNext = REF_CENTER;
  end

  assign refSel = refNext;

  assert_clear_on_mark_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && markSeen) |=> !losFlag);

  assert_los_on_empty_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losFlag) |-> $past(bitEn && !markSeen));

  assert_master_no_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |-> (refSel != REF_LINE));

  assert_ref_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(refSel));

  assert_present_after_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncEdge |=> syncPresent);

  assert_drop_needs_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncPresent) |-> $past(!syncEdge));

endmodule

// File: rtl/los_ref_select.sv
module los_ref_select
  import los_ref_pkg::*;
#(
  parameter int LOS_BITS    = 32,
  parameter int WIN_CEPT    = 16,
  parameter int WIN_T1      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxPosN,
  input  logic       rxNegN,
  input  logic       syncClk,
  input  logic       masterMode,
  input  logic       t1Mode,
  output logic       losFlag,
  output logic       outPosN,
  output logic       outNegN,
  output logic [1:0] refSel
);

  railCtl_t railCtl;
  logic     markSeen;
  logic     syncEdge;
  logic     syncPresent;

  los_ref_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .rxPosN   (rxPosN),
    .rxNegN   (rxNegN),
    .syncClk  (syncClk),
    .ctl      (railCtl),
    .markSeen (markSeen),
    .syncEdge (syncEdge),
    .outPosN  (outPosN),
    .outNegN  (outNegN)
  );

  los_ref_ctrl #(
    .LOS_BITS (LOS_BITS),
    .WIN_CEPT (WIN_CEPT),
    .WIN_T1   (WIN_T1)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitEn       (bitEn),
    .markSeen    (markSeen),
    .syncEdge    (syncEdge),
    .masterMode  (masterMode),
    .t1Mode      (t1Mode),
    .ctl         (railCtl),
    .losFlag     (losFlag),
    .syncPresent (syncPresent),
    .refSel      (refSel)
  );

  assert_slave_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !losFlag) |-> (refSel == 2'b00));

endmodule

// File: tb/tb_los_ref_select.sv
`timescale 1ns/1ps
module tb_los_ref_select;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxPosN = 1'b1;
  logic       rxNegN = 1'b1;
  logic       syncClk = 1'b0;
  logic       masterMode = 1'b0;
  logic       t1Mode = 1'b0;
  logic       losFlag;
  logic       outPosN;
  logic       outNegN;
  logic [1:0] refSel;

  int testsRun = 0;
  int testsFailed = 0;
  int zeroRun = 0;
  logic expLos = 1'b0;

  always #2.5 clk = ~clk;

  los_ref_select dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxPosN(rxPosN), .rxNegN(rxNegN),
    .syncClk(syncClk), .masterMode(masterMode), .t1Mode(t1Mode),
    .losFlag(losFlag), .outPosN(outPosN), .outNegN(outNegN), .refSel(refSel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one bit period; checks rails (R2/R3/R4) and flag (R1) against the model
  task automatic sendBit(input logic p, input logic n);
    logic [1:0] expOut;
    logic mark;
    @(negedge clk);
    rxPosN = p; rxNegN = n; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    mark = !p || !n;
    expOut = expLos ? 2'b11 : {p, n};
    if (mark) begin
      zeroRun = 0; expLos = 1'b0;
    end else begin
      if (zeroRun < 32) zeroRun++;
      if (zeroRun >= 32) expLos = 1'b1;
    end
    chk("R1 losFlag", losFlag, expLos);
    chk("R2/R3/R4 rails", {outPosN, outNegN}, expOut);
  endtask

  function automatic int expRef(input logic m, input logic los, input logic sp);
    if (!m && !los) return 0;
    return sp ? 1 : 2;
  endfunction

  initial begin
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R9 reset state
    chk("R9 losFlag", losFlag, 0);
    chk("R9 rails", {outPosN, outNegN}, 3);
    chk("R9 refSel slave", refSel, 0);
    masterMode = 1'b1;
    waitCycles(1);
    chk("R9/R7 refSel master no sync", refSel, 2);
    masterMode = 1'b0;

    // R3 mark patterns pass through
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    // R3 hold between strobes
    @(negedge clk); rxPosN = 1'b1; rxNegN = 1'b0;
    waitCycles(2);
    chk("R3 hold", {outPosN, outNegN}, 2'b01);

    // R1 sweep of zero-run lengths around the limit
    for (int len = 0; len <= 34; len++) begin
      sendBit(1'b0, 1'b1);
      for (int k = 0; k < len; k++) sendBit(1'b1, 1'b1);
      chk("R1 run end", losFlag, (len >= 32) ? 1 : 0);
    end

    // R2/R4: clearing bit idle, following bit passes, for each mark kind
    for (int kind = 0; kind < 3; kind++) begin
      logic p, n;
      p = (kind == 1); n = (kind == 0);
      for (int k = 0; k < 32; k++) sendBit(1'b1, 1'b1);
      chk("R1 los set", losFlag, 1);
      sendBit(p, n);
      chk("R4 cleared", losFlag, 0);
      chk("R2 idle on clearing bit", {outPosN, outNegN}, 3);
      sendBit(p, n);
      chk("R4 resume", {outPosN, outNegN}, {p, n});
    end

    // R8 sync window length in both standards
    for (int t = 0; t < 2; t++) begin
      int win;
      win = t ? 24 : 16;
      t1Mode = t[0];
      masterMode = 1'b1;
      syncClk = 1'b0;
      waitCycles(40);
      chk("R8 absent before", refSel, 2);
      syncClk = 1'b1;
      waitCycles(2);
      chk("R8 not yet present", refSel, 2);
      waitCycles(1);
      chk("R8 present edge 3", refSel, 1);
      waitCycles(win - 1);
      chk("R8 last present", refSel, 1);
      waitCycles(1);
      chk("R8 dropped after window", refSel, 2);
      syncClk = 1'b0;
    end
    t1Mode = 1'b0;
    masterMode = 1'b0;

    // R5/R6/R7 exhaustive decode sweep
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 2; l++) begin
        for (int s = 0; s < 2; s++) begin
          masterMode = m[0];
          if (l != 0) begin
            for (int k = 0; k < 32; k++) sendBit(1'b1, 1'b1);
          end else begin
            sendBit(1'b0, 1'b1);
          end
          syncClk = 1'b0;
          waitCycles(30);
          if (s != 0) begin
            syncClk = 1'b1;
            waitCycles(4);
          end
          chk($sformatf("R5/R6/R7 decode m%0d l%0d s%0d", m, l, s),
              refSel, expRef(m[0], l[0], s[0]));
          syncClk = 1'b0;
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule